// File: doc/BRIEF.md
# Match-Timer Watchdog Reset Controller

This block is a memory-mapped timer. A free-running up-counter advances once per microsecond. The microsecond tick is made by dividing the system clock by a parameter. A bank of match channels compares its registers against the counter. When the counter steps onto a channel's match value and that channel's interrupt enable is set, a sticky pending flag is raised. A level interrupt stays high while any flag is pending.

One channel, chosen by a parameter, also serves as the watchdog. When the counter steps onto that channel's match value, the block emits a single-cycle reset request, but only if both the watchdog arm bit and that channel's interrupt enable are set. Firing the request disarms the watchdog.

Software refreshes the watchdog in three steps. It takes a coherent snapshot of the counter through a write-triggered latch, adds the timeout in ticks, and writes the sum to the watchdog match register. The comparison is an exact equality, so the refresh works across the counter's wrap.

Top module: `mtw_ctrl`

## Requirements
- R1: After reset the counter, the snapshot, every enable bit and every pending bit are 0. Every match register holds all ones across the counter width. `irq` and `wdog_rst_req` are low.
- R2: The counter advances by exactly 1 every TICK_DIV clock cycles, starting from the release of reset. It wraps modulo 2^CNT_W. A read of offset 0x00 returns the counter value of the cycle in which the read was presented.
- R3: Read data appears on `bus_rdata` one clock cycle after a read request (bus_en=1, bus_wr=0). The readable locations are: 0x24, interrupt enables (bit n for channel n); 0x28, watchdog arm (bit 0); 0x2C, pending flags (bit n for channel n); 0x34, snapshot. Values narrower than 32 bits are zero-extended.
- R4: Channel n's match register sits at offset 0x08 + 4·n and takes bus_wdata[CNT_W-1:0] on a write. Bits above CNT_W read as 0.
- R5: Writing a value with bit 0 set to offset 0x30 copies the counter of that cycle into the snapshot at 0x34. The snapshot then holds until the next such write. A write to 0x30 with bit 0 clear has no effect.
- R6: When the counter steps onto a value equal to channel n's match register (exact equality, including after a wrap) and enable bit n is set, pending bit n is set. `irq` rises one cycle after the counter shows that value. With enable bit n clear, no pending bit is raised.
- R7: Writing to 0x2C clears the pending bits written as 1 and leaves the others set. `irq` falls once no bit is pending.
- R8: Writing to 0x28 sets the watchdog arm from bit 0: 1 arms it, 0 disarms it.
- R9: When the counter steps onto the watchdog channel's match value while armed and enabled, `wdog_rst_req` is high for exactly one cycle, beginning one cycle after the counter shows that value.
- R10: No reset request is produced while the watchdog channel's enable bit is clear, even when armed. None is produced while disarmed.
- R11: The watchdog arm reads 0 after a reset request has fired.
- R12: Reads of unmapped or unaligned offsets return 0 (this includes 0x04, 0x30, and match slots at or beyond NUM_CH). Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while any pending bit is set |
| wdog_rst_req | output | 1 | Single-cycle watchdog reset request |

## Verification
Each result has its own due cycle, counted from the edge that captures a request.

- Read data is due one cycle after the request.
- A snapshot reflects the counter at the capture edge of the latch write.
- `irq` and `wdog_rst_req` both rise one cycle after the counter shows the match value.

The bench keeps its own count of clock edges since the release of reset. From that count it predicts the counter as floor((edge−1)/TICK_DIV) mod 2^CNT_W for any capture edge, so every counter, snapshot and match-hit check compares against an arithmetic value. When it detects an event, the bench issues the counter read on the next cycle. At that point the counter must still equal the match value, which pins the event timing to the cycle.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned MAX_CH = 7;   // match slots that fit below 0x24

   localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h24;
   localparam logic [ADDR_W-1:0] OFS_WDEN    = 8'h28;
   localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h2C;
   localparam logic [ADDR_W-1:0] OFS_SNAP_GO = 8'h30;
   localparam logic [ADDR_W-1:0] OFS_SNAP    = 8'h34;
   localparam logic [ADDR_W-3:0] MATCH_WORD0 = 6'd2;  // 0x08 >> 2
endpackage

// File: rtl/mtw_tick.sv
module mtw_tick #(
   parameter int unsigned DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("mtw_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pc <= '0;
         else if (pc == LAST) pc <= '0;
         else                 pc <= pc + 1'b1;
      end
      assign tick = (pc == LAST);

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/mtw_counter.sv
module mtw_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         snap_go,
   output logic [W-1:0] cnt,
   output logic [W-1:0] snap,
   output logic         adv
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         snap <= '0;
         adv  <= 1'b0;
      end else begin
         adv <= tick;
         if (tick)    cnt  <= cnt + 1'b1;
         if (snap_go) snap <= cnt;
      end
   end

   // R2
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (cnt == $past(cnt) + W'(1)));
   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |-> $stable(cnt));
   // R5
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(snap_go) |-> $stable(snap));
endmodule

// File: rtl/mtw_match_bank.sv
module mtw_match_bank #(
   parameter int unsigned NCH = 6,
   parameter int unsigned W   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        wr_en,
   input  logic [W-1:0]          wdata,
   input  logic [W-1:0]          cnt,
   input  logic                  adv,
   output logic [NCH-1:0][W-1:0] match_q,
   output logic [NCH-1:0]        hit
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        match_q[i] <= '1;
         else if (wr_en[i]) match_q[i] <= wdata;
      end
      // equality only on the cycle the counter has just stepped
      assign hit[i] = adv && (cnt == match_q[i]);

      // R4
      match_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(wr_en[i]) |-> $stable(match_q[i]));
   end
endmodule

// File: rtl/mtw_ctrl.sv
module mtw_ctrl
   import mtw_pkg::*;
#(
   parameter int unsigned NUM_CH   = 6,
   parameter int unsigned WDOG_CH  = 5,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned TICK_DIV = 125
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_wr,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        wdog_rst_req
);
   localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("mtw_ctrl: NUM_CH must lie in 1..7");
   end
   if (WDOG_CH >= NUM_CH) begin : g_bad_wd
      $error("mtw_ctrl: WDOG_CH must name an existing channel");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
      $error("mtw_ctrl: CNT_W must lie in 2..32");
   end

   // ---------------- bus decode ----------------
   logic              wr_go, rd_go, in_match;
   logic [5:0]        word;
   logic [CH_W-1:0]   ch_idx;
   logic [NUM_CH-1:0] match_wr, clr_mask;
   logic              snap_go;

   assign wr_go    = bus_en && bus_wr;
   assign rd_go    = bus_en && !bus_wr;
   assign word     = bus_addr[7:2];
   assign in_match = (bus_addr[1:0] == 2'b00) && (word >= MATCH_WORD0)
                     && (word < MATCH_WORD0 + 6'(NUM_CH));
   assign ch_idx   = CH_W'(word - MATCH_WORD0);
   assign snap_go  = wr_go && (bus_addr == OFS_SNAP_GO) && bus_wdata[0];
   assign clr_mask = (wr_go && bus_addr == OFS_PEND) ? bus_wdata[NUM_CH-1:0] : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_mwr
      assign match_wr[i] = wr_go && in_match && (ch_idx == CH_W'(i));
   end

   // ---------------- datapath ----------------
   logic                       tick, adv;
   logic [CNT_W-1:0]           cnt, snap;
   logic [NUM_CH-1:0][CNT_W-1:0] match_q;
   logic [NUM_CH-1:0]          hit, hit_en;

   mtw_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   mtw_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .snap_go(snap_go),
      .cnt(cnt), .snap(snap), .adv(adv)
   );

   mtw_match_bank #(.NCH(NUM_CH), .W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(match_wr),
      .wdata(bus_wdata[CNT_W-1:0]), .cnt(cnt), .adv(adv),
      .match_q(match_q), .hit(hit)
   );

   // ---------------- control registers ----------------
   logic [NUM_CH-1:0] ien, pend;
   logic              wd_en, rst_q, wd_fire;

   assign hit_en  = hit & ien;
   assign wd_fire = hit_en[WDOG_CH] && wd_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien   <= '0;
         wd_en <= 1'b0;
         pend  <= '0;
         rst_q <= 1'b0;
      end else begin
         if (wr_go && bus_addr == OFS_IEN) ien <= bus_wdata[NUM_CH-1:0];
         if (wd_fire)                              wd_en <= 1'b0;
         else if (wr_go && bus_addr == OFS_WDEN)   wd_en <= bus_wdata[0];
         pend  <= (pend & ~clr_mask) | hit_en;    // a new hit beats a clear
         rst_q <= wd_fire;
      end
   end

   assign irq          = |pend;
   assign wdog_rst_req = rst_q;

   // ---------------- read path ----------------
   logic [CNT_W-1:0] mval;
   logic [31:0]      rd_val;

   always_comb begin
      mval = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_idx == CH_W'(i)) mval = match_q[i];
      end
   end

   always_comb begin
      rd_val = '0;
      if (in_match) rd_val = 32'(mval);
      else begin
         case (bus_addr)
            OFS_COUNT: rd_val = 32'(cnt);
            OFS_IEN:   rd_val = 32'(ien);
            OFS_WDEN:  rd_val = {31'b0, wd_en};
            OFS_PEND:  rd_val = 32'(pend);
            OFS_SNAP:  rd_val = 32'(snap);
            default:   rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_go) bus_rdata <= rd_val;
   end

   // R10
   wd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> ($past(ien[WDOG_CH]) && $past(wd_en)));
   // R9
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);
   // R11
   wd_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> !wd_en);
   // R7
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend) & ~$past(clr_mask)) & ~pend) == '0);
   // R6
   pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend)) & ~$past(hit_en)) == '0);
endmodule

// File: tb/mtw_ctrl_bench.sv
module mtw_ctrl_bench;
   localparam int NCH = 6;
   localparam int WD  = 5;
   localparam int CW  = 8;
   localparam int DIV = 4;
   localparam int MOD = 1 << CW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, wdog_rst_req;

   mtw_ctrl #(.NUM_CH(NCH), .WDOG_CH(WD), .CNT_W(CW), .TICK_DIV(DIV)) u_mtw_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .wdog_rst_req(wdog_rst_req)
   );

   always #4 clk = ~clk;   // 125 MHz

   int unsigned cyc = 0;
   int unsigned cap = 0;
   int unsigned total = 0, bad = 0;
   int unsigned rst_seen = 0, rst_long = 0;
   logic        prev_rst = 1'b0;
   logic        done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (wdog_rst_req) rst_seen++;
      if (wdog_rst_req && prev_rst) rst_long++;
      prev_rst = wdog_rst_req;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cap = cyc + 1;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      cap = cyc + 1;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   // counter value presented at capture edge c (edges counted from reset release)
   function automatic logic [31:0] cnt_at(input int unsigned c);
      return 32'(((c - 1) / DIV) % MOD);
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   logic [31:0] v;

   initial begin
      int unsigned snap_cap;
      logic [31:0] snap_exp, tgt;
      int unsigned n0;
      wait_cyc(3);
      rst_n = 1'b1;

      // ---- R1 reset state ----
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 rst_req", {31'b0, wdog_rst_req}, 0);
      rd(8'h00, v); chk("R1 counter", v, cnt_at(cap));
      for (int c = 0; c < NCH; c++) begin
         rd(8'(8 + 4*c), v); chk("R1 match all ones", v, 32'hFF);
      end
      rd(8'h24, v); chk("R1 ien", v, 0);
      rd(8'h28, v); chk("R1 wd arm", v, 0);
      rd(8'h2C, v); chk("R1 pending", v, 0);
      rd(8'h34, v); chk("R1 snapshot", v, 0);

      // ---- R4 match register sweep ----
      for (int c = 0; c < NCH; c++) begin
         wr(8'(8 + 4*c), 32'hA5 ^ 32'(c * 17));
         rd(8'(8 + 4*c), v); chk("R4 match rw", v, (32'hA5 ^ 32'(c * 17)) & 32'hFF);
         wr(8'(8 + 4*c), 32'hFFFF_FF00 | 32'(c));
         rd(8'(8 + 4*c), v); chk("R4 upper bits zero", v, 32'(c));
      end

      // ---- R12 unmapped / unaligned ----
      wr(8'h24, 32'h0);
      for (int k = 0; k < 8; k++) begin
         logic [7:0] a;
         case (k)
            0: a = 8'h04; 1: a = 8'h20; 2: a = 8'h38; 3: a = 8'h3C;
            4: a = 8'h80; 5: a = 8'hFC; 6: a = 8'h09; default: a = 8'h26;
         endcase
         wr(a, 32'hDEAD_BEEF);
         rd(a, v); chk("R12 unmapped reads zero", v, 0);
      end
      rd(8'h08, v); chk("R12 match0 untouched", v, 0);
      rd(8'h24, v); chk("R12 ien untouched", v, 0);
      rd(8'h30, v); chk("R12 latch trigger reads zero", v, 0);

      // ---- R2 / R3 counter rate and wrap ----
      for (int k = 0; k < 40; k++) begin
         rd(8'h00, v); chk("R2 live counter", v, cnt_at(cap));
         wait_cyc(29);
      end

      // ---- R5 snapshot ----
      for (int k = 1; k <= 5; k++) begin
         wr(8'h30, 32'h1);
         snap_cap = cap;
         snap_exp = cnt_at(snap_cap);
         wait_cyc(k * DIV + k);
         rd(8'h34, v); chk("R5 snapshot value", v, snap_exp);
         wr(8'h30, 32'h0);
         wait_cyc(DIV * 2);
         rd(8'h34, v); chk("R5 zero write no effect", v, snap_exp);
      end

      // ---- R6 / R7 match events with wrap ----
      for (int c = 0; c < NCH; c++) begin
         for (int t = 0; t < 3; t++) begin
            int d;
            int n;
            d = (t == 0) ? 6 : (t == 1) ? 57 : 200;
            wr(8'h2C, 32'h3F);
            wr(8'h24, 32'(1 << c));
            rd(8'h24, v); chk("R3 ien readback", v, 32'(1 << c));
            tgt = (cnt_at(cyc + 1) + 32'(d)) % MOD;
            wr(8'(8 + 4*c), tgt);
            n = 0;
            while (!irq && n < 1200) begin @(negedge clk); n++; end
            chk("R6 irq rose", {31'b0, irq}, 1);
            rd(8'h00, v); chk("R6 counter at event", v, tgt);
            rd(8'h2C, v); chk("R6 pending bit", v, 32'(1 << c));
            wr(8'h2C, 32'h3F & ~32'(1 << c));
            rd(8'h2C, v); chk("R7 other bits kept", v, 32'(1 << c));
            wr(8'h2C, 32'(1 << c));
            rd(8'h2C, v); chk("R7 cleared", v, 0);
            chk("R7 irq low", {31'b0, irq}, 0);
         end
      end

      // R6 no enable, no pending
      wr(8'h24, 32'h0);
      tgt = (cnt_at(cyc + 1) + 32'd6) % MOD;
      wr(8'h08, tgt);
      wait_cyc(60);
      rd(8'h2C, v); chk("R6 disabled channel no pending", v, 0);
      chk("R6 disabled irq low", {31'b0, irq}, 0);

      // ---- R8 arm bit ----
      wr(8'h28, 32'h1); rd(8'h28, v); chk("R8 arm", v, 1);
      wr(8'h28, 32'h0); rd(8'h28, v); chk("R8 disarm", v, 0);

      // ---- R10 armed but channel disabled ----
      n0 = rst_seen;
      wr(8'h24, 32'h0);
      wr(8'h28, 32'h1);
      tgt = (cnt_at(cyc + 1) + 32'd6) % MOD;
      wr(8'h1C, tgt);
      wait_cyc(60);
      chk("R10 no reset without enable", rst_seen - n0, 0);
      rd(8'h28, v); chk("R10 arm kept", v, 1);

      // ---- R10 enabled but disarmed ----
      wr(8'h28, 32'h0);
      wr(8'h24, 32'(1 << WD));
      tgt = (cnt_at(cyc + 1) + 32'd6) % MOD;
      wr(8'h1C, tgt);
      wait_cyc(60);
      chk("R10 no reset when disarmed", rst_seen - n0, 0);
      rd(8'h2C, v); chk("R6 watchdog channel pending", v, 32'(1 << WD));
      wr(8'h2C, 32'h3F);

      // ---- R9 / R11 firing ----
      wr(8'h28, 32'h1);
      tgt = (cnt_at(cyc + 1) + 32'd9) % MOD;
      wr(8'h1C, tgt);
      begin
         int n;
         n = 0;
         while (!wdog_rst_req && n < 200) begin @(negedge clk); n++; end
      end
      chk("R9 reset request seen", {31'b0, wdog_rst_req}, 1);
      rd(8'h00, v); chk("R9 counter at fire", v, tgt);
      wait_cyc(4);
      chk("R9 exactly one pulse", rst_seen - n0, 1);
      chk("R9 one cycle wide", rst_long, 0);
      rd(8'h28, v); chk("R11 arm cleared", v, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule